// File: doc/BRIEF.md
# Banded Affine-Gap Read Scorer

This block scores one short read against a stretch of reference sequence placed at a single candidate position. It runs affine-gap dynamic programming over a diagonal band of fixed half-width around the main diagonal. Bases arrive as 2-bit codes. The block fetches them itself through an index/symbol port pair, which the surrounding logic serves from its own symbol storage in the same cycle.

The read has to be consumed in full, so the matrix edges are seeded with gap penalties instead of zeros. Only one band-wide row of scores and vertical-gap values is kept, and there is no traceback. Cells are computed one per clock.

After each row the block finds the row maximum. It gives up early when that maximum sits on a band edge, or when the row holds no cell inside the reference. The result is one signed 21-bit score plus a flag that says whether every read row was completed inside the band.

Top module: `banded_read_scorer`

## Requirements
- R1: After reset, busy, done and covered are 0 and score is 0.
- R2: A start pulse while idle latches read_len (m) and ref_len (n), each at most MAX_LEN. A start pulse while busy has no effect on the running job or its result.
- R3: Symbols are 2-bit codes, and two symbols match exactly when their codes are equal. In the same cycle the block presents read_idx = i-1 and ref_idx = j-1 for cell (i,j), and it uses read_sym and ref_sym from that cycle.
- R4: The recurrences are E(i,j)=max(H(i,j-1)-d, E(i,j-1)-e), F(i,j)=max(H(i-1,j)-d, F(i-1,j)-e) and H(i,j)=max(H(i-1,j-1)+s, E, F). Here s is MATCH or MISMATCH. There is no floor at zero, so a gap of k symbols costs d+(k-1)e.
- R5: Edge cells are seeded as H(0,0)=0, H(0,k)=H(k,0)=-d-(k-1)e, with no gap state carried on an edge.
- R6: Only cells with |j-i| <= BAND_W and 0 <= j <= n are scored. Every other cell holds the score minimum.
- R7: done is high for exactly one cycle. score and covered change only in that cycle and hold until the next one.
- R8: A job that completes all m rows raises done m*(2*BAND_W+1)+1 cycles after the start is captured.
- R9: When row m completes, covered=1 and score is the maximum H of row m.
- R10: After a row i<m, take the leftmost maximum scanning j upward. If it lies at j=i-BAND_W or j=i+BAND_W, or if the row has no cell above the minimum, the job stops with covered=0 and score equal to that row maximum.
- R11: All score arithmetic is signed and saturates at -2^20 and 2^20-1.
- R12: A start with read_len=0 gives done one cycle later with score 0 and covered 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job (used only when idle) |
| read_len | input | LEN_W | Read length m |
| ref_len | input | LEN_W | Reference clip length n |
| read_idx | output | LEN_W | Read symbol index requested this cycle |
| ref_idx | output | LEN_W | Reference symbol index requested this cycle |
| read_sym | input | 2 | Read symbol at read_idx |
| ref_sym | input | 2 | Reference symbol at ref_idx |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle result strobe |
| score | output | 21 | Signed alignment score |
| covered | output | 1 | 1 when all read rows were completed in the band |

## Verification
A corrupted band entry or gap register changes the score of the cell that reads it, and that error reaches the row maximum. A wrong value can therefore show up at the ports as a wrong score, or as a covered flag that flips because the maximum moved onto an edge. In either case it appears at the next done strobe, which comes within one row time of the fault at the earliest. Faults in the row or offset counters show up sooner, as a changed done latency or as out-of-order symbol indices. The bench compares every result against an independent full-matrix banded model, and it also checks hand-derived values for the clean-diagonal, two-mismatch, band-exit, saturation and empty-read cases.

// File: rtl/aln_pkg.sv
package aln_pkg;
    localparam int SCORE_W = 21;
    typedef logic signed [SCORE_W-1:0] score_t;

    localparam score_t SCORE_NEG = {1'b1, {(SCORE_W-1){1'b0}}};
    localparam score_t SCORE_POS = {1'b0, {(SCORE_W-1){1'b1}}};

    typedef enum logic {ST_IDLE, ST_RUN} run_state_e;

    // clamp a wide signed value into the score range
    function automatic score_t sat_val(input int v);
        if (v < int'(SCORE_NEG)) return SCORE_NEG;
        if (v > int'(SCORE_POS)) return SCORE_POS;
        return score_t'(v);
    endfunction

    function automatic score_t sat_add(input score_t a, input int b);
        return sat_val(int'(a) + b);
    endfunction

    function automatic score_t smax(input score_t a, input score_t b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/aln_cell.sv
module aln_cell
    import aln_pkg::*;
#(
    parameter int MATCH    = 2,
    parameter int MISMATCH = -3,
    parameter int GAP_OPEN = 5,
    parameter int GAP_EXT  = 1
) (
    input  logic       valid,
    input  logic       boundary,
    input  score_t     bnd_val,
    input  logic [1:0] sym_a,
    input  logic [1:0] sym_b,
    input  score_t     diag_h,
    input  score_t     up_h,
    input  score_t     up_f,
    input  score_t     left_h,
    input  score_t     left_e,
    output score_t     cell_h,
    output score_t     cell_e,
    output score_t     cell_f
);
    score_t e_val, f_val, dg_val;

    always_comb begin
        e_val  = smax(sat_add(left_h, -GAP_OPEN), sat_add(left_e, -GAP_EXT));
        f_val  = smax(sat_add(up_h, -GAP_OPEN), sat_add(up_f, -GAP_EXT));
        dg_val = sat_add(diag_h, (sym_a == sym_b) ? MATCH : MISMATCH);
        if (!valid) begin
            cell_h = SCORE_NEG;
            cell_e = SCORE_NEG;
            cell_f = SCORE_NEG;
        end else if (boundary) begin
            cell_h = bnd_val;
            cell_e = SCORE_NEG;
            cell_f = SCORE_NEG;
        end else begin
            cell_e = e_val;
            cell_f = f_val;
            cell_h = smax(dg_val, smax(e_val, f_val));
        end
    end
endmodule

// File: rtl/aln_band_store.sv
module aln_band_store
    import aln_pkg::*;
#(
    parameter int BAND_W   = 4,
    parameter int GAP_OPEN = 5,
    parameter int GAP_EXT  = 1,
    parameter int LEN_W    = 9,
    localparam int BW      = 2 * BAND_W + 1,
    localparam int OFF_W   = $clog2(BW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic [LEN_W-1:0] init_n,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] off,
    input  score_t           wr_h,
    input  score_t           wr_f,
    output score_t           diag_h,
    output score_t           up_h,
    output score_t           up_f
);
    score_t h_q [BW];
    score_t f_q [BW];
    score_t init_v [BW];

    // row-zero seed per band slot, column = slot - BAND_W
    for (genvar k = 0; k < BW; k++) begin : g_seed
        localparam int COL = k - BAND_W;
        if (COL < 0) begin : g_left
            assign init_v[k] = SCORE_NEG;
        end else if (COL == 0) begin : g_origin
            assign init_v[k] = '0;
        end else begin : g_right
            assign init_v[k] = (COL <= int'(init_n))
                ? sat_val(-(GAP_OPEN + (COL - 1) * GAP_EXT)) : SCORE_NEG;
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < BW; k++) begin
            if (!rst_n) begin
                h_q[k] <= SCORE_NEG;
                f_q[k] <= SCORE_NEG;
            end else if (init) begin
                h_q[k] <= init_v[k];
                f_q[k] <= SCORE_NEG;
            end else if (wr_en && (int'(off) == k)) begin
                h_q[k] <= wr_h;
                f_q[k] <= wr_f;
            end
        end
    end

    always_comb begin
        diag_h = h_q[off];
        if (int'(off) < BW - 1) begin
            up_h = h_q[OFF_W'(off + 1'b1)];
            up_f = f_q[OFF_W'(off + 1'b1)];
        end else begin
            up_h = SCORE_NEG;
            up_f = SCORE_NEG;
        end
    end
endmodule

// File: rtl/banded_read_scorer.sv
module banded_read_scorer
    import aln_pkg::*;
#(
    parameter int MAX_LEN  = 400,
    parameter int BAND_W   = 4,
    parameter int MATCH    = 2,
    parameter int MISMATCH = -3,
    parameter int GAP_OPEN = 5,
    parameter int GAP_EXT  = 1,
    localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [LEN_W-1:0]          read_len,
    input  logic [LEN_W-1:0]          ref_len,
    output logic [LEN_W-1:0]          read_idx,
    output logic [LEN_W-1:0]          ref_idx,
    input  logic [1:0]                read_sym,
    input  logic [1:0]                ref_sym,
    output logic                      busy,
    output logic                      done,
    output logic signed [SCORE_W-1:0] score,
    output logic                      covered
);
    localparam int BW    = 2 * BAND_W + 1;
    localparam int OFF_W = $clog2(BW);
    localparam int J_W   = LEN_W + 2;

    typedef struct packed {
        run_state_e       state;
        logic [LEN_W-1:0] m;
        logic [LEN_W-1:0] n;
        logic [LEN_W-1:0] row;
        logic [OFF_W-1:0] off;
        score_t           h_left;
        score_t           e_left;
        score_t           best;
        logic [OFF_W-1:0] best_off;
        logic             done;
        logic             covered;
        score_t           score;
    } scorer_t;

    scorer_t q, d;

    logic signed [J_W-1:0] col_j;
    logic                  cell_valid, cell_bnd, band_init, band_wr;
    score_t                bnd_val, diag_h, up_h, up_f, cell_h, cell_e, cell_f;

    assign col_j = $signed({2'b00, q.row}) + $signed({{(J_W-OFF_W){1'b0}}, q.off})
                 - $signed(J_W'(BAND_W));
    assign cell_valid = (col_j >= 0) && (col_j <= $signed({2'b00, q.n}));
    assign cell_bnd   = (col_j == 0);
    assign bnd_val    = sat_val(-(GAP_OPEN + (int'(q.row) - 1) * GAP_EXT));
    assign read_idx   = (q.row != '0) ? q.row - 1'b1 : '0;
    assign ref_idx    = (col_j >= 1) ? LEN_W'(col_j - 1) : '0;
    assign band_init  = (q.state == ST_IDLE) && start && (read_len != '0);
    assign band_wr    = (q.state == ST_RUN);

    aln_band_store #(
        .BAND_W(BAND_W), .GAP_OPEN(GAP_OPEN), .GAP_EXT(GAP_EXT), .LEN_W(LEN_W)
    ) store_i (
        .clk(clk), .rst_n(rst_n), .init(band_init), .init_n(ref_len),
        .wr_en(band_wr), .off(q.off), .wr_h(cell_h), .wr_f(cell_f),
        .diag_h(diag_h), .up_h(up_h), .up_f(up_f)
    );

    aln_cell #(
        .MATCH(MATCH), .MISMATCH(MISMATCH), .GAP_OPEN(GAP_OPEN), .GAP_EXT(GAP_EXT)
    ) cell_i (
        .valid(cell_valid), .boundary(cell_bnd), .bnd_val(bnd_val),
        .sym_a(read_sym), .sym_b(ref_sym),
        .diag_h(diag_h), .up_h(up_h), .up_f(up_f),
        .left_h(q.h_left), .left_e(q.e_left),
        .cell_h(cell_h), .cell_e(cell_e), .cell_f(cell_f)
    );

    always_comb begin
        score_t           nb;
        logic [OFF_W-1:0] nbo;
        d      = q;
        d.done = 1'b0;
        nb     = q.best;
        nbo    = q.best_off;
        unique case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.m        = read_len;
                    d.n        = ref_len;
                    d.row      = LEN_W'(1);
                    d.off      = '0;
                    d.h_left   = SCORE_NEG;
                    d.e_left   = SCORE_NEG;
                    d.best     = SCORE_NEG;
                    d.best_off = '0;
                    if (read_len == '0) begin
                        d.done    = 1'b1;
                        d.score   = '0;
                        d.covered = 1'b1;
                    end else begin
                        d.state = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (cell_h > q.best) begin
                    nb  = cell_h;
                    nbo = q.off;
                end
                d.h_left = cell_h;
                d.e_left = cell_e;
                if (int'(q.off) == BW - 1) begin
                    if (q.row == q.m) begin
                        d.state   = ST_IDLE;
                        d.done    = 1'b1;
                        d.covered = 1'b1;
                        d.score   = nb;
                    end else if (nbo == '0 || int'(nbo) == BW - 1) begin
                        d.state   = ST_IDLE;
                        d.done    = 1'b1;
                        d.covered = 1'b0;
                        d.score   = nb;
                    end else begin
                        d.row      = q.row + 1'b1;
                        d.off      = '0;
                        d.h_left   = SCORE_NEG;
                        d.e_left   = SCORE_NEG;
                        d.best     = SCORE_NEG;
                        d.best_off = '0;
                    end
                end else begin
                    d.off      = q.off + 1'b1;
                    d.best     = nb;
                    d.best_off = nbo;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q          <= '0;
            q.state    <= ST_IDLE;
            q.h_left   <= SCORE_NEG;
            q.e_left   <= SCORE_NEG;
            q.best     <= SCORE_NEG;
        end else begin
            q <= d;
        end
    end

    assign busy    = (q.state == ST_RUN);
    assign done    = q.done;
    assign score   = q.score;
    assign covered = q.covered;
endmodule

// File: rtl/banded_read_scorer_chk.sv
module banded_read_scorer_chk #(
    parameter int MAX_LEN = 400,
    parameter int LEN_W   = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [LEN_W-1:0] read_idx,
    input logic             busy,
    input logic             done,
    input logic [20:0]      score,
    input logic             covered
);
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(score) && $stable(covered)));

    a_r2_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r2_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    a_r3_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (int'(read_idx) < MAX_LEN));
endmodule

bind banded_read_scorer banded_read_scorer_chk #(
    .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .read_idx(read_idx),
    .busy(busy), .done(done), .score(score), .covered(covered)
);

// File: tb/banded_read_scorer_tb_top.sv
module banded_read_scorer_tb_top;
    localparam int MAXL = 400;
    localparam int LW   = 9;
    localparam int BWH  = 4;
    localparam int MA = 2, MI = -3, GO = 5, GE = 1;
    localparam int S_MI = -600000, S_GO = 600000, S_GE = 600000;
    localparam int NEG = -1048576;
    localparam int POS = 1048575;

    logic clk = 0, rst_n = 0;
    always #5 clk = ~clk;

    logic          start = 0, start2 = 0;
    logic [LW-1:0] read_len = '0, ref_len = '0;
    logic [LW-1:0] read_idx, ref_idx, read_idx2, ref_idx2;
    logic [1:0]    read_sym, ref_sym, read_sym2, ref_sym2;
    logic          busy, done, covered, busy2, done2, covered2;
    logic signed [20:0] score, score2;

    logic [1:0] rd_mem [0:MAXL-1];
    logic [1:0] rf_mem [0:MAXL-1];
    assign read_sym  = rd_mem[read_idx];
    assign ref_sym   = rf_mem[ref_idx];
    assign read_sym2 = rd_mem[read_idx2];
    assign ref_sym2  = rf_mem[ref_idx2];

    banded_read_scorer #(.MAX_LEN(MAXL), .BAND_W(BWH), .MATCH(MA), .MISMATCH(MI),
        .GAP_OPEN(GO), .GAP_EXT(GE)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .read_len(read_len), .ref_len(ref_len),
        .read_idx(read_idx), .ref_idx(ref_idx), .read_sym(read_sym), .ref_sym(ref_sym),
        .busy(busy), .done(done), .score(score), .covered(covered));

    banded_read_scorer #(.MAX_LEN(MAXL), .BAND_W(BWH), .MATCH(MA), .MISMATCH(S_MI),
        .GAP_OPEN(S_GO), .GAP_EXT(S_GE)) dut_sat_i (
        .clk(clk), .rst_n(rst_n), .start(start2), .read_len(read_len), .ref_len(ref_len),
        .read_idx(read_idx2), .ref_idx(ref_idx2), .read_sym(read_sym2), .ref_sym(ref_sym2),
        .busy(busy2), .done(done2), .score(score2), .covered(covered2));

    int total = 0, bad = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        if (v < NEG) return NEG;
        if (v > POS) return POS;
        return v;
    endfunction

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [1:0] gsym(input int k, input int seed);
        return 2'((k * k * 5 + k * 3 + seed * 7 + (k >> 2)) % 4);
    endfunction

    // independent full-row banded model built from R4..R6, R9..R11
    task automatic model(input int m, input int n, input int ma, input int mi,
                         input int go, input int ge, output int sc, output int cv);
        int hp [0:MAXL];
        int fp [0:MAXL];
        int hc [0:MAXL];
        int fc [0:MAXL];
        int e, hl, best, bj, h, en, f, up, fu, dg;
        if (m == 0) begin sc = 0; cv = 1; return; end
        for (int j = 0; j <= n; j++) begin
            hp[j] = (j == 0) ? 0 : ((j <= BWH) ? sat(-(go + (j - 1) * ge)) : NEG);
            fp[j] = NEG;
        end
        for (int i = 1; i <= m; i++) begin
            e = NEG; hl = NEG; best = NEG; bj = i - BWH;
            for (int j = i - BWH; j <= i + BWH; j++) begin
                if (j < 0 || j > n) begin
                    h = NEG; en = NEG; f = NEG;
                end else if (j == 0) begin
                    h = sat(-(go + (i - 1) * ge)); en = NEG; f = NEG;
                end else begin
                    en = mx(sat(hl - go), sat(e - ge));
                    up = (j - (i - 1) <= BWH) ? hp[j] : NEG;
                    fu = (j - (i - 1) <= BWH) ? fp[j] : NEG;
                    f  = mx(sat(up - go), sat(fu - ge));
                    dg = sat(hp[j - 1] + ((rd_mem[i - 1] == rf_mem[j - 1]) ? ma : mi));
                    h  = mx(dg, mx(en, f));
                end
                if (j >= 0 && j <= n) begin hc[j] = h; fc[j] = f; end
                hl = h; e = en;
                if (h > best) begin best = h; bj = j; end
            end
            for (int j = mx(0, i - BWH); j <= n && j <= i + BWH; j++) begin
                hp[j] = hc[j]; fp[j] = fc[j];
            end
            if (i == m) begin sc = best; cv = 1; return; end
            if (bj == i - BWH || bj == i + BWH) begin sc = best; cv = 0; return; end
        end
        sc = 0; cv = 1;
    endtask

    task automatic run(input int m, input int n, input bool_busy_poke,
                       output int sc, output int cv, output int lat);
        int s, w;
        @(negedge clk);
        read_len = LW'(m); ref_len = LW'(n); start = 1; s = cyc;
        @(negedge clk);
        start = 0;
        if (bool_busy_poke) begin
            repeat (3) @(negedge clk);
            read_len = '0; ref_len = LW'(1); start = 1;
            @(negedge clk);
            start = 0;
        end
        w = 0;
        while (!done && w < 20000) begin @(negedge clk); w++; end
        if (w >= 20000) chk("watchdog job", 0, 1);
        sc = int'(score); cv = int'(covered); lat = cyc - s;
    endtask

    task automatic expect_model(input string tag, input int m, input int n,
                                input int sc, input int cv);
        int esc, ecv;
        model(m, n, MA, MI, GO, GE, esc, ecv);
        chk({tag, " score"}, sc, esc);
        chk({tag, " covered"}, cv, ecv);
    endtask

    task automatic t_reset();
        chk("R1 done", int'(done), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 score", int'(score), 0);
        chk("R1 covered", int'(covered), 0);
    endtask

    task automatic t_identical();
        int sc, cv, lat;
        for (int k = 0; k < 12; k++) begin rd_mem[k] = gsym(k, 1); rf_mem[k] = rd_mem[k]; end
        run(12, 12, 0, sc, cv, lat);
        chk("R9 identical score", sc, 24);
        chk("R9 identical covered", cv, 1);
        chk("R8 latency", lat, 12 * (2 * BWH + 1) + 1);
        expect_model("R4 identical", 12, 12, sc, cv);
    endtask

    task automatic t_mismatch();
        int sc, cv, lat;
        for (int k = 0; k < 12; k++) begin rd_mem[k] = gsym(k, 2); rf_mem[k] = rd_mem[k]; end
        rf_mem[3] = rf_mem[3] ^ 2'b01;
        rf_mem[8] = rf_mem[8] ^ 2'b10;
        run(12, 12, 0, sc, cv, lat);
        chk("R3 two mismatches score", sc, 14);
        chk("R3 two mismatches covered", cv, 1);
    endtask

    task automatic t_read_insert();
        int sc, cv, lat;
        for (int k = 0; k < 20; k++) rf_mem[k] = gsym(k, 3);
        for (int k = 0; k < 21; k++)
            rd_mem[k] = (k < 10) ? rf_mem[k] : ((k == 10) ? ~rf_mem[10] : rf_mem[k - 1]);
        run(21, 20, 0, sc, cv, lat);
        expect_model("R4 read insertion", 21, 20, sc, cv);
    endtask

    task automatic t_ref_insert();
        int sc, cv, lat;
        for (int k = 0; k < 21; k++) rf_mem[k] = gsym(k, 4);
        for (int k = 0; k < 20; k++) rd_mem[k] = (k < 7) ? rf_mem[k] : rf_mem[k + 1];
        run(20, 21, 0, sc, cv, lat);
        expect_model("R5 reference insertion", 20, 21, sc, cv);
    endtask

    task automatic t_band_exit();
        int sc, cv, lat;
        for (int k = 0; k < 20; k++) begin rd_mem[k] = gsym(k, 5); rf_mem[k] = rd_mem[k]; end
        run(20, 3, 0, sc, cv, lat);
        chk("R6 band exit covered", cv, 0);
        expect_model("R10 band exit", 20, 3, sc, cv);
    endtask

    task automatic t_shifted();
        int sc, cv, lat;
        for (int k = 0; k < 40; k++) rf_mem[k] = gsym(k, 6);
        for (int k = 0; k < 30; k++) rd_mem[k] = rf_mem[k + 7];
        run(30, 40, 0, sc, cv, lat);
        expect_model("R10 shifted reference", 30, 40, sc, cv);
    endtask

    task automatic t_start_busy();
        int sc, cv, lat;
        for (int k = 0; k < 12; k++) begin rd_mem[k] = gsym(k, 1); rf_mem[k] = rd_mem[k]; end
        run(12, 12, 1, sc, cv, lat);
        chk("R2 start while busy score", sc, 24);
        chk("R2 start while busy latency", lat, 12 * (2 * BWH + 1) + 1);
    endtask

    task automatic t_zero();
        int sc, cv, lat;
        run(0, 5, 0, sc, cv, lat);
        chk("R12 empty read score", sc, 0);
        chk("R12 empty read covered", cv, 1);
        chk("R12 empty read latency", lat, 1);
        @(negedge clk);
        chk("R7 done one cycle", int'(done), 0);
        chk("R7 score held", int'(score), 0);
    endtask

    task automatic t_saturate();
        int w, esc, ecv;
        rd_mem[0] = 2'd0; rd_mem[1] = 2'd0; rf_mem[0] = 2'd1; rf_mem[1] = 2'd1;
        @(negedge clk);
        read_len = LW'(2); ref_len = LW'(2); start2 = 1;
        @(negedge clk);
        start2 = 0;
        w = 0;
        while (!done2 && w < 1000) begin @(negedge clk); w++; end
        chk("R11 saturated score", int'(score2), NEG);
        chk("R11 saturated covered", int'(covered2), 1);
        model(2, 2, MA, S_MI, S_GO, S_GE, esc, ecv);
        chk("R11 saturated vs model", int'(score2), esc);
    endtask

    initial begin
        for (int k = 0; k < MAXL; k++) begin rd_mem[k] = '0; rf_mem[k] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_identical();
        t_mismatch();
        t_read_insert();
        t_ref_insert();
        t_band_exit();
        t_shifted();
        t_start_busy();
        t_zero();
        t_saturate();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1500000;
        chk("watchdog run", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule